// File: doc/BRIEF.md
# Function Configuration Register File

This block is the target-side register file that answers configuration cycles for one function of a peripheral on a shared parallel bus. It holds a 256-byte configuration space. The low 64 bytes follow the standard header arrangement. A parameterised window of device-specific scratch dwords starts at byte 64. Every other offset is empty. The block answers only while its own per-slot select line is high. Accesses are dword-aligned, and four byte enables pick the lanes, so 8-, 16- and 32-bit transfers all use the same port. All multi-byte fields are little-endian: the least significant byte sits at the lowest offset.

The identification fields (vendor, device, revision, programming interface, class, header type and interrupt pin) are fixed by parameters and cannot be written. The command register drives three registered enables to the rest of the function: I/O decode, memory decode and bus mastering. All three are cleared by reset, so after reset the function answers nothing but configuration accesses. The interrupt line byte is a plain read/write field that firmware programs. It is also presented on an output port for other logic.

Top module: `fncfg_space`

## Requirements
- R1: While and after a synchronous reset, `io_en`, `mem_en`, `mst_en`, `irq_line` and `cfg_rvalid` are 0 and `cfg_rdata` is 0.
- R2: The dword at byte offset 0 reads {DEVICE_ID, VENDOR_ID}. The vendor identifier occupies bytes 0-1 (bits 15:0) and the device identifier occupies bytes 2-3 (bits 31:16).
- R3: The dword at offset 8 reads {CLASS_CODE, PROG_IF, REVISION}. The base class is byte 11. Byte 14 (bits 23:16 of dword 12) reads {MULTI_FN, 7'b0}, and the rest of that dword reads 0. Writes to all identification bytes are ignored.
- R4: The command register is at offset 4. Bit 0 drives `io_en`, bit 1 drives `mem_en` and bit 2 drives `mst_en`. Bits 31:3 of that dword read 0, and the outputs change on the clock edge that takes the write.
- R5: Byte 60 is the read/write interrupt line, and it is shown on `irq_line`. Byte 61 is the read-only interrupt pin, which reads IRQ_PIN (0 = no interrupt, 1-4 = pin). Bytes 62-63 read 0.
- R6: A write changes only the byte lanes whose `cfg_be` bit is set. Bit n selects bits 8n+7:8n, and `cfg_be` = 0 writes nothing.
- R7: While `cfg_sel` is low, writes change nothing, and reads give `cfg_rvalid` = 0 with `cfg_rdata` = 0.
- R8: Bits 1:0 of `cfg_off` are ignored, so the access goes to the dword at `cfg_off[7:2]`.
- R9: Dwords 16 to 16+EXT_DWORDS-1 (byte 64 upward) are read/write storage with per-lane enables.
- R10: Every other offset reads 0 and ignores writes. This covers header dwords 4-14 and all dwords past the scratch window.
- R11: A selected read gives `cfg_rvalid` = 1 and the data in the cycle after the request. A read and a write to the same dword in the same cycle return the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | Per-slot configuration select |
| cfg_rd | input | 1 | Read request (with select) |
| cfg_wr | input | 1 | Write request (with select) |
| cfg_off | input | 8 | Byte offset into the configuration space |
| cfg_be | input | 4 | Byte-lane enables |
| cfg_wdata | input | 32 | Write data, little-endian lanes |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after request |
| io_en | output | 1 | I/O space decode enable |
| mem_en | output | 1 | Memory space decode enable |
| mst_en | output | 1 | Bus master enable |
| irq_line | output | 8 | Programmed interrupt line value |
| irq_pin | output | 8 | Constant interrupt pin code |

## Verification
The hardest situation to reach from the ports is a read and a write that hit the same scratch dword in one cycle. The result depends on the read-first ordering inside the storage lanes. The bench drives both strobes together on a dword whose old contents it knows, then reads back to see the new value. It also shows that read-only and empty offsets ignore writes: it first writes all-ones to all 64 dwords and then sweeps every offset, using a different value of the low offset bits each time. Byte-lane handling is covered by stepping through all 16 enable patterns on both a scratch dword and the command register.

// File: rtl/fncfg_pkg.sv
package fncfg_pkg;
  localparam int DW_W = 6;
  typedef logic [DW_W-1:0] dword_idx_t;

  // dword indices whose position other logic depends on
  localparam dword_idx_t DW_IDENT    = 6'd0;
  localparam dword_idx_t DW_CMD      = 6'd1;
  localparam dword_idx_t DW_CLASS    = 6'd2;
  localparam dword_idx_t DW_HTYPE    = 6'd3;
  localparam dword_idx_t DW_IRQ      = 6'd15;
  localparam dword_idx_t DW_EXT_BASE = 6'd16;
  localparam int         DW_TOTAL    = 64;

  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;
  localparam int CMD_MST_BIT = 2;
endpackage

// File: rtl/fncfg_hdr.sv
module fncfg_hdr
  import fncfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'h7A31,
  parameter logic [15:0] CLASS_CODE = 16'h0480,
  parameter logic [7:0]  PROG_IF    = 8'h00,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter bit          MULTI_FN   = 1'b1,
  parameter logic [7:0]  IRQ_PIN    = 8'd2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  dword_idx_t  dw,
  input  logic        be0,
  input  logic [7:0]  wbyte,
  output logic [31:0] rd_val,
  output logic        io_en,
  output logic        mem_en,
  output logic        mst_en,
  output logic [7:0]  irq_line
);
  logic [2:0] cmd_q;
  logic [7:0] line_q;
  logic [4:0] wbyte_unused;

  assign wbyte_unused = wbyte[7:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      line_q <= '0;
    end else if (wr_en && be0) begin
      if (dw == DW_CMD) cmd_q  <= wbyte[2:0];
      if (dw == DW_IRQ) line_q <= wbyte;
    end
  end

  always_comb begin
    case (dw)
      DW_IDENT: rd_val = {DEVICE_ID, VENDOR_ID};
      DW_CMD:   rd_val = {29'd0, cmd_q};
      DW_CLASS: rd_val = {CLASS_CODE, PROG_IF, REVISION};
      DW_HTYPE: rd_val = {8'h00, MULTI_FN, 7'h00, 16'h0000};
      DW_IRQ:   rd_val = {16'h0000, IRQ_PIN, line_q};
      default:  rd_val = 32'd0;
    endcase
  end

  assign io_en    = cmd_q[CMD_IO_BIT];
  assign mem_en   = cmd_q[CMD_MEM_BIT];
  assign mst_en   = cmd_q[CMD_MST_BIT];
  assign irq_line = line_q;
endmodule

// File: rtl/fncfg_ext.sv
module fncfg_ext #(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  // one inferable RAM per byte lane, read-first
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rd_en) q <= mem[addr];
      if (wr_en && be[l]) mem[addr] <= wdata[8*l +: 8];
    end
    assign rdata[8*l +: 8] = q;
  end
endmodule

// File: rtl/fncfg_space.sv
module fncfg_space
  import fncfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID   = 16'h7A31,
  parameter logic [15:0] CLASS_CODE  = 16'h0480,
  parameter logic [7:0]  PROG_IF     = 8'h00,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter bit          MULTI_FN    = 1'b1,
  parameter logic [7:0]  IRQ_PIN     = 8'd2,
  parameter int          EXT_DWORDS  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_sel,
  input  logic        cfg_rd,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_off,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rvalid,
  output logic        io_en,
  output logic        mem_en,
  output logic        mst_en,
  output logic [7:0]  irq_line,
  output logic [7:0]  irq_pin
);
  localparam int EXT_AW  = (EXT_DWORDS > 1) ? $clog2(EXT_DWORDS) : 1;
  localparam int EXT_END = int'(DW_EXT_BASE) + EXT_DWORDS;

  dword_idx_t        dw;
  logic              acc_rd, acc_wr, in_ext;
  logic [EXT_AW-1:0] ext_addr;
  logic [31:0]       hdr_val, ext_q, hdr_q;
  logic              ext_hit_q, rvalid_q;
  logic              off_lo_unused;

  assign dw            = cfg_off[7:2];
  assign off_lo_unused = ^cfg_off[1:0];
  assign acc_rd        = cfg_sel && cfg_rd;
  assign acc_wr        = cfg_sel && cfg_wr;
  assign in_ext        = (int'(dw) >= int'(DW_EXT_BASE)) && (int'(dw) < EXT_END);
  assign ext_addr      = EXT_AW'(dw - DW_EXT_BASE);

  fncfg_hdr #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .PROG_IF(PROG_IF), .REVISION(REVISION), .MULTI_FN(MULTI_FN), .IRQ_PIN(IRQ_PIN)
  ) u_hdr (
    .clk(clk), .rst(rst), .wr_en(acc_wr), .dw(dw), .be0(cfg_be[0]),
    .wbyte(cfg_wdata[7:0]), .rd_val(hdr_val),
    .io_en(io_en), .mem_en(mem_en), .mst_en(mst_en), .irq_line(irq_line)
  );

  fncfg_ext #(.DEPTH(EXT_DWORDS)) u_ext (
    .clk(clk), .wr_en(acc_wr && in_ext), .rd_en(acc_rd && in_ext),
    .addr(ext_addr), .be(cfg_be), .wdata(cfg_wdata), .rdata(ext_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      ext_hit_q <= 1'b0;
      hdr_q     <= '0;
    end else begin
      rvalid_q  <= acc_rd;
      ext_hit_q <= acc_rd && in_ext;
      hdr_q     <= acc_rd ? hdr_val : 32'd0;
    end
  end

  assign cfg_rvalid = rvalid_q;
  assign cfg_rdata  = hdr_q | (ext_hit_q ? ext_q : 32'd0);
  assign irq_pin    = IRQ_PIN;
endmodule

// File: rtl/fncfg_chk.sv
module fncfg_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID = 16'h7A31
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_sel,
  input logic        cfg_rd,
  input logic        cfg_wr,
  input logic [7:0]  cfg_off,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_rdata,
  input logic        cfg_rvalid,
  input logic        io_en,
  input logic        mem_en,
  input logic        mst_en,
  input logic [7:0]  irq_line
);
  AST_RESET_DISABLES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!io_en && !mem_en && !mst_en && irq_line == 8'd0)); // R1

  AST_IDENT_READ: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel && cfg_rd && cfg_off[7:2] == 6'd0) |=> (cfg_rdata == {DEVICE_ID, VENDOR_ID})); // R2

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel && cfg_rd) |=> cfg_rvalid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(cfg_sel && cfg_rd) |=> (!cfg_rvalid && cfg_rdata == 32'd0)); // R7

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cfg_sel && cfg_wr) |=> $stable({io_en, mem_en, mst_en})); // R7

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cfg_sel && cfg_wr && cfg_off[7:2] == 6'd15 && cfg_be[0]) |=> $stable(irq_line)); // R5
endmodule

bind fncfg_space fncfg_chk #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) i_chk (
  .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
  .cfg_off(cfg_off), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
  .io_en(io_en), .mem_en(mem_en), .mst_en(mst_en), .irq_line(irq_line)
);

// File: tb/test_fncfg_space.sv
`timescale 1ns/1ps
module test_fncfg_space;
  localparam logic [15:0] VEN  = 16'h1D0F;
  localparam logic [15:0] DEV  = 16'h7A31;
  localparam logic [15:0] CLS  = 16'h0480;
  localparam logic [7:0]  PIF  = 8'h00;
  localparam logic [7:0]  REV  = 8'h03;
  localparam bit          MFN  = 1'b1;
  localparam logic [7:0]  PIN  = 8'd2;
  localparam int          EXTN = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_sel = 0, cfg_rd = 0, cfg_wr = 0;
  logic [7:0]  cfg_off = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid, io_en, mem_en, mst_en;
  logic [7:0]  irq_line, irq_pin;

  int checks = 0;
  int errors = 0;

  logic [2:0]  sh_cmd  = 0;
  logic [7:0]  sh_line = 0;
  logic [31:0] sh_ext [EXTN];

  always #2.5 clk = ~clk;

  fncfg_space #(
    .VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_CODE(CLS), .PROG_IF(PIF),
    .REVISION(REV), .MULTI_FN(MFN), .IRQ_PIN(PIN), .EXT_DWORDS(EXTN)
  ) i_fncfg_space (.*);

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int l = 0; l < 4; l++) if (be[l]) r[8*l +: 8] = n[8*l +: 8];
    return r;
  endfunction

  function automatic logic [31:0] expect_dw(int d);
    if (d == 0)  return {DEV, VEN};
    if (d == 1)  return {29'd0, sh_cmd};
    if (d == 2)  return {CLS, PIF, REV};
    if (d == 3)  return {8'h00, MFN, 7'h00, 16'h0};
    if (d == 15) return {16'h0, PIN, sh_line};
    if (d >= 16 && d < 16 + EXTN) return sh_ext[d-16];
    return 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply shadow update for a selected write
  task automatic shadow_wr(int d, logic [3:0] be, logic [31:0] data);
    if (d == 1 && be[0]) sh_cmd = data[2:0];
    if (d == 15 && be[0]) sh_line = data[7:0];
    if (d >= 16 && d < 16 + EXTN) sh_ext[d-16] = merge(sh_ext[d-16], data, be);
  endtask

  task automatic do_wr(int d, logic [1:0] lo, logic [3:0] be, logic [31:0] data, logic sel);
    @(negedge clk);
    cfg_sel = sel; cfg_wr = 1; cfg_rd = 0;
    cfg_off = {d[5:0], lo}; cfg_be = be; cfg_wdata = data;
    @(negedge clk);
    cfg_sel = 0; cfg_wr = 0;
    if (sel) shadow_wr(d, be, data);
  endtask

  task automatic do_rd(int d, logic [1:0] lo, string req);
    @(negedge clk);
    cfg_sel = 1; cfg_rd = 1; cfg_wr = 0; cfg_off = {d[5:0], lo};
    @(negedge clk);
    check(req, cfg_rdata, expect_dw(d));
    check("R11 rvalid", {31'd0, cfg_rvalid}, 32'd1);
    cfg_sel = 0; cfg_rd = 0;
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 enables", {29'd0, io_en, mem_en, mst_en}, 32'd0);
    check("R1 irq_line", {24'd0, irq_line}, 32'd0);
    check("R1 rvalid/rdata", {cfg_rvalid, cfg_rdata[30:0]}, 32'd0);
    rst = 0;
    @(negedge clk);

    // R9 fill the scratch window with computed patterns
    for (int i = 0; i < EXTN; i++)
      do_wr(16 + i, 2'(i), 4'hF, (i * 32'h01010101) ^ 32'hA5C3_0000, 1'b1);

    // R2 R3 R5 R8 R9 R10 full sweep, low offset bits rotating
    for (int d = 0; d < 64; d++) do_rd(d, 2'(d), "R2/R3/R5/R8/R9/R10 sweep");

    // all-ones to every dword; read-only and empty offsets must not change
    for (int d = 0; d < 64; d++) do_wr(d, 2'(3 - (d % 4)), 4'hF, 32'hFFFF_FFFF, 1'b1);
    for (int d = 0; d < 64; d++) do_rd(d, 2'(d + 1), "R3/R10 after all-ones write");
    check("R4 all enables on", {29'd0, io_en, mem_en, mst_en}, 32'd7);
    check("R5 irq_line port", {24'd0, irq_line}, 32'hFF);
    check("R5 irq_pin port", {24'd0, irq_pin}, {24'd0, PIN});

    // R6 every byte-enable pattern on scratch dword 20 and on command
    for (int b = 0; b < 16; b++) begin
      do_wr(20, 2'd0, 4'(b), 32'h1122_3344 + b * 32'h0101_0101, 1'b1);
      do_rd(20, 2'd2, "R6 lane write");
      do_wr(1, 2'd1, 4'(b), {24'd0, 5'd0, 3'(b)}, 1'b1);
      do_rd(1, 2'd0, "R6 command lanes");
    end

    // R4 each enable alone
    for (int k = 0; k < 3; k++) begin
      do_wr(1, 2'd0, 4'h1, 32'd1 << k, 1'b1);
      check("R4 enable bit", {29'd0, mst_en, mem_en, io_en}, 32'd1 << k);
    end

    // R7 unselected write and read
    do_wr(1, 2'd0, 4'hF, 32'd0, 1'b0);
    check("R7 cmd unchanged", {29'd0, mst_en, mem_en, io_en}, 32'd4);
    do_wr(15, 2'd0, 4'hF, 32'h0, 1'b0);
    check("R7 line unchanged", {24'd0, irq_line}, {24'd0, sh_line});
    @(negedge clk);
    cfg_sel = 0; cfg_rd = 1; cfg_off = 8'd0;
    @(negedge clk);
    check("R7 no response", {cfg_rvalid, cfg_rdata[30:0]}, 32'd0);
    cfg_rd = 0;

    // R5 interrupt line value
    do_wr(15, 2'd0, 4'h1, 32'h0000_0A2B, 1'b1);
    check("R5 irq_line value", {24'd0, irq_line}, 32'h2B);
    do_rd(15, 2'd1, "R5 line/pin read");

    // R11 read and write same dword same cycle: old contents returned
    @(negedge clk);
    cfg_sel = 1; cfg_rd = 1; cfg_wr = 1; cfg_off = 8'd68; cfg_be = 4'hF;
    cfg_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R11 read-first", cfg_rdata, sh_ext[1]);
    cfg_sel = 0; cfg_rd = 0; cfg_wr = 0;
    shadow_wr(17, 4'hF, 32'hDEAD_BEEF);
    do_rd(17, 2'd0, "R11 new value after collision");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule